// File: doc/BRIEF.md
# Asymmetric-Width FIFO With Programmable Flags

This block is a first-in first-out buffer whose write word and read word differ in width by a power-of-two ratio. Examples are a 72-bit producer feeding an 18-bit consumer, or an 8-bit producer feeding a 32-bit consumer. Storage is organised in slices of the narrower width. The write pointer and the read pointer each count whole words of their own port and advance by themselves on every accepted transfer. When the write side is wider, each word leaves the read port least-significant slice first. When the read side is wider, incoming words are packed into the read word starting at the least-significant slice.

A build parameter selects between two clocking modes. In the first, both ports share one clock and the flags are exact. In the second, the two clocks are unrelated and each pointer crosses into the other domain as Gray code through two flip-flops. In that mode full and empty may stay asserted longer than strictly needed, but they never drop too early.

Occupancy is counted in narrow slices. The user supplies two threshold inputs in the same unit: one for the almost-full flag and one for the almost-empty flag. A write into a full FIFO or a read from an empty FIFO changes nothing and sets a sticky flag that only reset clears.

Top module: `asym_fifo`

## Requirements
- R1: When the write port is wider, each accepted write stores WR_W/RD_W read words. They leave the read port in order, bits [RD_W-1:0] of the written word first, then the next slice up.
- R2: When the read port is wider, each read word is assembled from RD_W/WR_W consecutive accepted writes. The earliest write occupies bits [WR_W-1:0], the next write the next slice up.
- R3: `full` is high exactly when the free space, as seen by the write side, is smaller than one write word. A write attempted while `full` is high stores nothing and leaves the write pointer unchanged. It also sets `overflow`, which stays high until reset.
- R4: `empty` is high exactly when the occupancy, as seen by the read side, is smaller than one whole read word. A read attempted while `empty` is high consumes nothing. It also sets `underflow`, which stays high until reset.
- R5: `prog_full` is high when the write-side occupancy, in narrow slices, is greater than or equal to `pfull_lvl`.
- R6: `prog_empty` is high when the read-side occupancy, in narrow slices, is less than or equal to `pempty_lvl`.
- R7: Whenever `empty` is low, `rd_data` presents the oldest unread word. A read with `empty` low moves on to the next word at that read-clock edge. Data written in order is read back in the same order, with no loss and no duplication.
- R8: With DUAL_CLOCK=0 (both ports on one clock), `empty` falls in the same cycle that the write completing the first whole read word takes effect. Likewise, `full` falls in the same cycle that the freeing read takes effect.
- R9: With DUAL_CLOCK=1, a write becomes visible on the read side only after two read-clock edges. A read becomes visible on the write side only after two write-clock edges. `empty` and `full` are never low while the real occupancy would require them high.
- R10: While `rst_n` is low, both pointers clear. `empty` and `prog_empty` (with a threshold of zero or more) read 1, and `full`, `prog_full` (with a non-zero threshold), `overflow` and `underflow` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock (tie to wr_clk when DUAL_CLOCK=0) |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| full | output | 1 | No room for one more write word |
| prog_full | output | 1 | Write-side occupancy at or above `pfull_lvl` |
| overflow | output | 1 | Sticky: a write was attempted while full |
| pfull_lvl | input | clog2(DEPTH)+1 | Almost-full threshold in narrow slices (write domain, quasi-static) |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Oldest unread word (valid while `empty` is low) |
| empty | output | 1 | Less than one whole read word stored |
| prog_empty | output | 1 | Read-side occupancy at or below `pempty_lvl` |
| underflow | output | 1 | Sticky: a read was attempted while empty |
| pempty_lvl | input | clog2(DEPTH)+1 | Almost-empty threshold in narrow slices (read domain, quasi-static) |

## Verification
The bench builds two instances. The first uses 32-bit writes, 8-bit reads, 32 slices of storage and unrelated clocks of 20 ns and 14 ns. This brings the write-wide slice order, the two-edge visibility delay across the crossing, and a full condition after eight writes within reach. The second uses 8-bit writes, 32-bit reads, 16 slices and one shared clock. This makes the read-wide packing order, the rule that a partial word keeps `empty` high, and the exact single-clock flag timing observable. In both instances the thresholds sit at non-trivial slice counts, so that each programmable flag can be seen on both sides of its edge.

// File: rtl/asym_fifo_pkg.sv
package asym_fifo_pkg;

    // Width of one storage slice: the narrower of the two port widths.
    function automatic int slice_width(input int wr_w, input int rd_w);
        return (wr_w < rd_w) ? wr_w : rd_w;
    endfunction

    // Number of storage slices that one port word spans.
    function automatic int slices_per_word(input int port_w, input int slice_w);
        return port_w / slice_w;
    endfunction

endpackage

// File: rtl/asym_fifo_ptr_sync.sv
// Carries a Gray-coded pointer into the destination clock domain and
// decodes it back to binary. DUAL selects the two-flop crossing (1)
// or a direct path for a shared clock (0).
module asym_fifo_ptr_sync #(
    parameter int PTR_W = 5,
    parameter int DUAL  = 1
) (
    input  logic             dst_clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] src_gray,
    output logic [PTR_W-1:0] dst_bin
);

    typedef struct packed {
        logic [PTR_W-1:0] s1;
        logic [PTR_W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;
    logic [PTR_W-1:0] sel_gray;
    logic             acc;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = src_gray;
        sync_d.s2 = sync_q.s1;
        sel_gray  = (DUAL != 0) ? sync_q.s2 : src_gray;
        acc       = 1'b0;
        for (int i = PTR_W - 1; i >= 0; i--) begin
            acc        = acc ^ sel_gray[i];
            dst_bin[i] = acc;
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

endmodule

// File: rtl/asym_fifo_wr_ctl.sv
// Write-side pointer, full / almost-full flags and overflow record.
module asym_fifo_wr_ctl #(
    parameter int DEPTH = 64,
    parameter int WRS   = 4,
    parameter int PW    = 7,
    parameter int LWS   = 2,
    parameter int WPW   = 5
) (
    input  logic           wr_clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [PW-1:0]  rd_ptr_sync_n,
    input  logic [PW-1:0]  pfull_lvl,
    output logic           full,
    output logic           prog_full,
    output logic           overflow,
    output logic           wr_go,
    output logic [PW-1:0]  wr_ptr_n,
    output logic [WPW-1:0] wr_gray
);

    typedef struct packed {
        logic [WPW-1:0] ptr;
        logic [WPW-1:0] gray;
        logic           ovf;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PW-1:0] occ;

    always_comb begin
        st_d      = st_q;
        wr_ptr_n  = PW'(st_q.ptr) << LWS;
        occ       = wr_ptr_n - rd_ptr_sync_n;
        full      = occ > PW'(DEPTH - WRS);
        prog_full = occ >= pfull_lvl;
        wr_go     = wr_en && !full;
        if (wr_go) begin
            st_d.ptr  = st_q.ptr + 1'b1;
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
        if (wr_en && full) st_d.ovf = 1'b1;
        overflow = st_q.ovf;
        wr_gray  = st_q.gray;
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/asym_fifo_rd_ctl.sv
// Read-side pointer, empty / almost-empty flags and underflow record.
module asym_fifo_rd_ctl #(
    parameter int RDS = 1,
    parameter int PW  = 7,
    parameter int LRS = 0,
    parameter int RPW = 7
) (
    input  logic           rd_clk,
    input  logic           rst_n,
    input  logic           rd_en,
    input  logic [PW-1:0]  wr_ptr_sync_n,
    input  logic [PW-1:0]  pempty_lvl,
    output logic           empty,
    output logic           prog_empty,
    output logic           underflow,
    output logic [PW-1:0]  rd_ptr_n,
    output logic [RPW-1:0] rd_gray
);

    typedef struct packed {
        logic [RPW-1:0] ptr;
        logic [RPW-1:0] gray;
        logic           udf;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [PW-1:0] occ;
    logic          rd_go;

    always_comb begin
        st_d       = st_q;
        rd_ptr_n   = PW'(st_q.ptr) << LRS;
        occ        = wr_ptr_sync_n - rd_ptr_n;
        empty      = occ < PW'(RDS);
        prog_empty = occ <= pempty_lvl;
        rd_go      = rd_en && !empty;
        if (rd_go) begin
            st_d.ptr  = st_q.ptr + 1'b1;
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
        if (rd_en && empty) st_d.udf = 1'b1;
        underflow = st_q.udf;
        rd_gray   = st_q.gray;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/asym_fifo_store.sv
// Slice-organised storage: a write fills WRS consecutive slices and a
// read presents RDS consecutive slices, lowest address in the low bits.
module asym_fifo_store #(
    parameter int NW    = 18,
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int WRS   = 4,
    parameter int RDS   = 1
) (
    input  logic              wr_clk,
    input  logic              wr_go,
    input  logic [AW-1:0]     wr_base,
    input  logic [WRS*NW-1:0] wr_data,
    input  logic [AW-1:0]     rd_base,
    output logic [RDS*NW-1:0] rd_data
);

    logic [NW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_go) begin
            for (int s = 0; s < WRS; s++) begin
                mem[wr_base + AW'(s)] <= wr_data[s*NW +: NW];
            end
        end
    end

    for (genvar s = 0; s < RDS; s++) begin : g_rd_slice
        assign rd_data[s*NW +: NW] = mem[rd_base + AW'(s)];
    end

endmodule

// File: rtl/asym_fifo.sv
module asym_fifo #(
    parameter int WR_W       = 72,
    parameter int RD_W       = 18,
    parameter int DEPTH      = 64,
    parameter int DUAL_CLOCK = 1
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WR_W-1:0]          wr_data,
    output logic                     full,
    output logic                     prog_full,
    output logic                     overflow,
    input  logic [$clog2(DEPTH):0]   pfull_lvl,
    input  logic                     rd_en,
    output logic [RD_W-1:0]          rd_data,
    output logic                     empty,
    output logic                     prog_empty,
    output logic                     underflow,
    input  logic [$clog2(DEPTH):0]   pempty_lvl
);

    localparam int NW  = asym_fifo_pkg::slice_width(WR_W, RD_W);
    localparam int WRS = asym_fifo_pkg::slices_per_word(WR_W, NW);
    localparam int RDS = asym_fifo_pkg::slices_per_word(RD_W, NW);
    localparam int AW  = $clog2(DEPTH);
    localparam int PW  = AW + 1;
    localparam int LWS = $clog2(WRS);
    localparam int LRS = $clog2(RDS);
    localparam int WPW = PW - LWS;
    localparam int RPW = PW - LRS;

    logic [PW-1:0]  wr_ptr_n, rd_ptr_n;
    logic [PW-1:0]  wr_ptr_sync_n, rd_ptr_sync_n;
    logic [WPW-1:0] wr_gray, wr_bin_r;
    logic [RPW-1:0] rd_gray, rd_bin_w;
    logic           wr_go;

    asym_fifo_wr_ctl #(
        .DEPTH(DEPTH), .WRS(WRS), .PW(PW), .LWS(LWS), .WPW(WPW)
    ) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en),
        .rd_ptr_sync_n(rd_ptr_sync_n), .pfull_lvl(pfull_lvl),
        .full(full), .prog_full(prog_full), .overflow(overflow),
        .wr_go(wr_go), .wr_ptr_n(wr_ptr_n), .wr_gray(wr_gray)
    );

    asym_fifo_rd_ctl #(
        .RDS(RDS), .PW(PW), .LRS(LRS), .RPW(RPW)
    ) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en),
        .wr_ptr_sync_n(wr_ptr_sync_n), .pempty_lvl(pempty_lvl),
        .empty(empty), .prog_empty(prog_empty), .underflow(underflow),
        .rd_ptr_n(rd_ptr_n), .rd_gray(rd_gray)
    );

    asym_fifo_ptr_sync #(.PTR_W(WPW), .DUAL(DUAL_CLOCK)) u_w2r (
        .dst_clk(rd_clk), .rst_n(rst_n), .src_gray(wr_gray), .dst_bin(wr_bin_r)
    );

    asym_fifo_ptr_sync #(.PTR_W(RPW), .DUAL(DUAL_CLOCK)) u_r2w (
        .dst_clk(wr_clk), .rst_n(rst_n), .src_gray(rd_gray), .dst_bin(rd_bin_w)
    );

    assign wr_ptr_sync_n = PW'(wr_bin_r) << LWS;
    assign rd_ptr_sync_n = PW'(rd_bin_w) << LRS;

    asym_fifo_store #(
        .NW(NW), .DEPTH(DEPTH), .AW(AW), .WRS(WRS), .RDS(RDS)
    ) u_store (
        .wr_clk(wr_clk), .wr_go(wr_go), .wr_base(wr_ptr_n[AW-1:0]),
        .wr_data(wr_data), .rd_base(rd_ptr_n[AW-1:0]), .rd_data(rd_data)
    );

endmodule

// File: rtl/asym_fifo_chk.sv
module asym_fifo_chk #(
    parameter int WR_W  = 72,
    parameter int RD_W  = 18,
    parameter int DEPTH = 64
) (
    input logic                   wr_clk,
    input logic                   rd_clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic                   full,
    input logic                   empty,
    input logic                   overflow,
    input logic                   underflow,
    input logic [$clog2(DEPTH):0] wr_ptr_n,
    input logic [$clog2(DEPTH):0] rd_ptr_n
);

    localparam int PW = $clog2(DEPTH) + 1;
    localparam int NW = (WR_W < RD_W) ? WR_W : RD_W;
    localparam logic [PW-1:0] WSTEP = PW'(WR_W / NW);
    localparam logic [PW-1:0] RSTEP = PW'(RD_W / NW);
    localparam logic [PW-1:0] CAP   = PW'(DEPTH);

    AST_WR_REFUSED_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wr_ptr_n)); // R3
    AST_OVERFLOW_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
        overflow |=> overflow); // R3
    AST_NO_OVERFILL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        PW'(wr_ptr_n - rd_ptr_n) <= CAP); // R3
    AST_RD_REFUSED_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rd_ptr_n)); // R4
    AST_UNDERFLOW_STICKY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        underflow |=> underflow); // R4
    AST_NO_OVERDRAIN: assert property (@(posedge rd_clk) disable iff (!rst_n)
        PW'(wr_ptr_n - rd_ptr_n) <= CAP); // R9
    AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && !full) |=> (wr_ptr_n == PW'($past(wr_ptr_n) + WSTEP))); // R1
    AST_RD_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && !empty) |=> (rd_ptr_n == PW'($past(rd_ptr_n) + RSTEP))); // R2

endmodule

bind asym_fifo asym_fifo_chk #(.WR_W(WR_W), .RD_W(RD_W), .DEPTH(DEPTH)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow),
    .wr_ptr_n(wr_ptr_n), .rd_ptr_n(rd_ptr_n)
);

// File: tb/sim_asym_fifo.sv
`timescale 1ns/1ps
module sim_asym_fifo;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic rst_n = 1'b0;
    always #10 wclk = ~wclk;   // 50 MHz
    always #7  rclk = ~rclk;   // unrelated read clock for u0

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // u0: 32-bit writes, 8-bit reads, 32 slices, dual clock
    logic        wr_en0 = 1'b0, rd_en0 = 1'b0;
    logic [31:0] wr_data0 = '0;
    logic [7:0]  rd_data0;
    logic        full0, empty0, pf0, pe0, ov0, ud0;
    logic [5:0]  pfl0 = 6'd12, pel0 = 6'd4;
    // u1: 8-bit writes, 32-bit reads, 16 slices, single clock
    logic        wr_en1 = 1'b0, rd_en1 = 1'b0;
    logic [7:0]  wr_data1 = '0;
    logic [31:0] rd_data1;
    logic        full1, empty1, pf1, pe1, ov1, ud1;
    logic [4:0]  pfl1 = 5'd15, pel1 = 5'd7;

    logic [7:0] q0[$];
    logic [7:0] q1[$];
    int rd_cnt0 = 0;

    asym_fifo #(.WR_W(32), .RD_W(8), .DEPTH(32), .DUAL_CLOCK(1)) u0 (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n),
        .wr_en(wr_en0), .wr_data(wr_data0), .full(full0), .prog_full(pf0),
        .overflow(ov0), .pfull_lvl(pfl0), .rd_en(rd_en0), .rd_data(rd_data0),
        .empty(empty0), .prog_empty(pe0), .underflow(ud0), .pempty_lvl(pel0)
    );

    asym_fifo #(.WR_W(8), .RD_W(32), .DEPTH(16), .DUAL_CLOCK(0)) u1 (
        .wr_clk(wclk), .rd_clk(wclk), .rst_n(rst_n),
        .wr_en(wr_en1), .wr_data(wr_data1), .full(full1), .prog_full(pf1),
        .overflow(ov1), .pfull_lvl(pfl1), .rd_en(rd_en1), .rd_data(rd_data1),
        .empty(empty1), .prog_empty(pe1), .underflow(ud1), .pempty_lvl(pel1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drivers: one call is one clock cycle; expected slices go to the queue.
    task automatic wr0(input logic [31:0] d, output bit acc);
        @(negedge wclk);
        wr_en0 = 1'b1; wr_data0 = d;
        acc = !full0;
        if (acc) for (int s = 0; s < 4; s++) q0.push_back(d[s*8 +: 8]);
        @(posedge wclk); #1 wr_en0 = 1'b0;
    endtask

    task automatic rd0();
        @(negedge rclk); rd_en0 = 1'b1;
        @(posedge rclk); #1 rd_en0 = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] d, output bit acc);
        @(negedge wclk);
        wr_en1 = 1'b1; wr_data1 = d;
        acc = !full1;
        if (acc) q1.push_back(d);
        @(posedge wclk); #1 wr_en1 = 1'b0;
    endtask

    task automatic rd1();
        @(negedge wclk); rd_en1 = 1'b1;
        @(posedge wclk); #1 rd_en1 = 1'b0;
    endtask

    // Monitors: compare what each accepted read returns against the queue.
    always @(negedge rclk) begin
        #1;
        if (rd_en0 && !empty0) begin
            if (q0.size() == 0) chk("R7 u0 data with nothing expected", 64'(rd_data0), 64'hdead);
            else chk("R1 R7 u0 slice order", 64'(rd_data0), 64'(q0.pop_front()));
            rd_cnt0++;
        end
    end

    always @(negedge wclk) begin
        #1;
        if (rd_en1 && !empty1) begin
            if (q1.size() < 4) chk("R7 u1 data with nothing expected", 64'(rd_data1), 64'hdead);
            else begin
                logic [31:0] w;
                for (int s = 0; s < 4; s++) w[s*8 +: 8] = q1.pop_front();
                chk("R2 R7 u1 packing", 64'(rd_data1), 64'(w));
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=completed");
            finish_up();
            $finish;
        end
    end

    initial begin
        bit a;
        repeat (3) @(negedge wclk);
        // R10: reset state
        chk("R10 u0 {empty,full,pfull,pempty,ovf,udf}", 64'({empty0, full0, pf0, pe0, ov0, ud0}), 64'b100100);
        chk("R10 u1 {empty,full,pfull,pempty,ovf,udf}", 64'({empty1, full1, pf1, pe1, ov1, ud1}), 64'b100100);
        rst_n = 1'b1;
        repeat (3) @(negedge wclk);

        // ---------------- u0: wide write, narrow read, two clocks
        rd0();
        chk("R4 u0 read on empty sets underflow", 64'(ud0), 64'd1);
        chk("R4 u0 still empty", 64'(empty0), 64'd1);

        wr0(32'h44332211, a);
        chk("R9 u0 empty not dropped before crossing", 64'(empty0), 64'd1);
        repeat (3) @(posedge rclk); #1;
        chk("R9 u0 empty drops after two read edges", 64'(empty0), 64'd0);
        chk("R1 u0 head is low slice", 64'(rd_data0), 64'h11);
        chk("R6 u0 prog_empty at 4 slices", 64'(pe0), 64'd1);

        wr0(32'h88776655, a);
        chk("R5 u0 prog_full low at 8 slices", 64'(pf0), 64'd0);
        wr0(32'hccbbaa99, a);
        chk("R5 u0 prog_full high at 12 slices", 64'(pf0), 64'd1);
        for (int i = 0; i < 4; i++) wr0(32'h01020304 * (i + 3), a);
        chk("R3 u0 not full at 28 slices", 64'(full0), 64'd0);
        wr0(32'hf0e0d0c0, a);
        chk("R3 u0 full at 32 slices", 64'(full0), 64'd1);
        wr0(32'hbad0bad0, a);
        chk("R3 u0 write while full refused", 64'(a), 64'd0);
        chk("R3 u0 overflow sticky", 64'(ov0), 64'd1);
        repeat (4) @(posedge rclk); #1;
        chk("R6 u0 prog_empty low at 32 slices", 64'(pe0), 64'd0);

        rd_cnt0 = 0;
        for (int g = 0; g < 100 && !empty0; g++) rd0();
        chk("R3 R4 u0 drained slice count", 64'(rd_cnt0), 64'd32);
        chk("R4 u0 empty after drain", 64'(empty0), 64'd1);
        chk("R7 u0 scoreboard empty", 64'(q0.size()), 64'd0);
        repeat (4) @(posedge wclk); #1;
        chk("R9 u0 full released after crossing", 64'(full0), 64'd0);

        // concurrent traffic across the two clocks
        rd_cnt0 = 0;
        fork
            begin
                for (int i = 0; i < 24; i++) begin
                    bit ok;
                    ok = 1'b0;
                    for (int t = 0; t < 200 && !ok; t++) wr0((32'h9e3779b9 * (i + 1)) ^ 32'h5a5a0000, ok);
                end
            end
            begin
                for (int g = 0; g < 2000 && rd_cnt0 < 96; g++) rd0();
            end
        join
        chk("R7 u0 stream slice count", 64'(rd_cnt0), 64'd96);
        chk("R7 u0 stream scoreboard empty", 64'(q0.size()), 64'd0);

        // ---------------- u1: narrow write, wide read, one clock
        for (int i = 1; i <= 3; i++) wr1(8'(i), a);
        @(negedge wclk); @(negedge wclk);
        chk("R4 u1 partial word keeps empty", 64'(empty1), 64'd1);
        wr1(8'h04, a);
        chk("R8 u1 empty low right after 4th byte", 64'(empty1), 64'd0);
        chk("R2 u1 packed word", 64'(rd_data1), 64'h04030201);
        for (int i = 5; i <= 14; i++) wr1(8'(i), a);
        chk("R5 u1 prog_full low at 14", 64'(pf1), 64'd0);
        wr1(8'h0f, a);
        chk("R5 u1 prog_full high at 15", 64'(pf1), 64'd1);
        chk("R3 u1 not full at 15", 64'(full1), 64'd0);
        wr1(8'h10, a);
        chk("R3 u1 full at 16", 64'(full1), 64'd1);
        wr1(8'hee, a);
        chk("R3 u1 write while full refused", 64'(a), 64'd0);
        chk("R3 u1 overflow sticky", 64'(ov1), 64'd1);
        chk("R6 u1 prog_empty low at 16", 64'(pe1), 64'd0);
        rd1();
        chk("R8 u1 full low right after read", 64'(full1), 64'd0);
        rd1();
        chk("R6 u1 prog_empty low at 8", 64'(pe1), 64'd0);
        rd1();
        chk("R6 u1 prog_empty high at 4", 64'(pe1), 64'd1);
        rd1();
        chk("R4 u1 empty after last word", 64'(empty1), 64'd1);
        chk("R4 u1 no underflow yet", 64'(ud1), 64'd0);
        rd1();
        chk("R4 u1 read on empty sets underflow", 64'(ud1), 64'd1);
        chk("R7 u1 scoreboard empty", 64'(q1.size()), 64'd0);

        done = 1'b1;
        finish_up();
        $finish;
    end

endmodule